// File: doc/BRIEF.md
# Prioritized Edge-Triggered Interrupt Controller

The block collects interrupt trigger events from eight fixed sources (three timer underflow pulses, edges on four general port pins, any falling edge across a group of port pins, and an optional comparator) into an eight-bit pending-flag register. Each flag is gated by an enable bit in a mask register. The highest-priority level that is both pending and enabled is presented to the processor as a request line plus a level number. Both registers are reached through a simple port-addressed bus. A read returns the register whose address is on the bus. A write strobe loads it.

Events always latch, whether or not the level is enabled. The flag register has no reset, so its contents survive a reset of the controller. The mask clears on reset, and no level can then request service. An acknowledge from the processor clears the flag of the level currently presented.

Port pins and the comparator pass through a two-stage synchronizer. A small warm-up state machine holds edge detection off until the synchronizer holds two samples taken after reset. Its states are `SYNC_WARM_A` (entered on reset), `SYNC_WARM_B` and `SYNC_WARM_C`. Each moves to the next on every clock. `SYNC_WARM_C` moves to `SYNC_ARMED`, which holds until the next reset. Edges are detected only in `SYNC_ARMED`.

Top module: `evirq_ctrl`

## Requirements
- R1: A read at address 0x38 returns the mask register on `io_rdata` bits 7:0, a read at 0x39 returns the flag register, and any other address reads 0. Writes to 0x38 load the mask and writes to 0x39 load the flags.
- R2: Asserting `rst_n` low leaves the flag register unchanged.
- R3: The mask register clears to 0 on reset. With the mask at 0, `irq` stays low whatever flags are pending.
- R4: Flag bit n is set by this source: bit 0 by a `dac_uf` pulse, bit 1 by `t1_uf`, bit 2 by `t2_uf`, bit 3 by a rising edge of `pd_pin[0]`, bit 4 by a falling edge of `pd_pin[1]`, bit 6 by a rising edge of `pd_pin[2]`, and bit 7 by a falling edge of `pd_pin[3]`. The opposite edge on those pins sets nothing.
- R5: An event sets its flag bit even while the matching mask bit is 0.
- R6: `irq` is high exactly when some bit is set in both the flags and the mask. `irq_level` is then the lowest such bit index, since bit 0 has the highest priority. `irq_level` is 0 when `irq` is low.
- R7: A write to 0x39 loads the written value. An event arriving in the same cycle still sets its bit.
- R8: `irq_ack` sampled high while `irq` is high clears the flag at `irq_level` on that clock edge. The acknowledge has no effect while `irq` is low. A same-cycle event on that bit keeps it set, and a same-cycle write to 0x39 takes precedence over the acknowledge.
- R9: A pin edge first sampled at clock edge n sets its flag bit at clock edge n+2.
- R10: Pin levels applied while reset is low never produce an event. Only a difference between two samples taken after reset release is detected.
- R11: With `cmp_en` high, bit 6 is set by a rising edge and bit 7 by a falling edge of `cmp_in`, and `pd_pin[2]` and `pd_pin[3]` are ignored. With `cmp_en` low, `cmp_in` is ignored.
- R12: Bit 5 is set by a falling edge on any bit of `pf_pin`. A rising edge there sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (mask and synchronizer only) |
| io_addr | input | ADDR_W | Port address for read and write |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for the addressed register |
| dac_uf | input | 1 | DAC timer underflow pulse, synchronous |
| t1_uf | input | 1 | Timer 1 underflow pulse, synchronous |
| t2_uf | input | 1 | Timer 2 underflow pulse, synchronous |
| pd_pin | input | 4 | Port pins for levels 3, 4, 6 and 7 (asynchronous) |
| pf_pin | input | PF_W | Port pin group, any falling edge sets level 5 (asynchronous) |
| cmp_in | input | 1 | Comparator output (asynchronous) |
| cmp_en | input | 1 | Selects the comparator as the source for levels 6 and 7 |
| irq_ack | input | 1 | Acknowledge of the presented level |
| irq | output | 1 | Interrupt request |
| irq_level | output | 3 | Level number of the request |

## Verification
The bench targets events that coincide with a flag write, an acknowledge, or each other. A design that let the write or the acknowledge win would silently drop an interrupt. Retention is checked by loading flags, pulsing reset and reading them back, which catches a flag register wrongly tied to reset. A pin is also moved while reset is held: a design without the warm-up gating would latch a spurious edge. The bench times the first flag after a pin change to the exact cycle and swaps the source of levels 6 and 7 with `cmp_en`, so an extra synchronizer stage or a swapped mux leg shows as a wrong value in one cycle.

// File: rtl/evirq_pkg.sv
package evirq_pkg;

    localparam int unsigned NUM_LVL = 8;
    localparam int unsigned LVL_W   = $clog2(NUM_LVL);

    // Level numbers; priority falls with the index
    localparam int unsigned LVL_DAC = 0;
    localparam int unsigned LVL_T1  = 1;
    localparam int unsigned LVL_T2  = 2;
    localparam int unsigned LVL_D2R = 3;
    localparam int unsigned LVL_D3F = 4;
    localparam int unsigned LVL_PFF = 5;
    localparam int unsigned LVL_D4R = 6;
    localparam int unsigned LVL_D5F = 7;

    // Positions in the synchronized pin vector
    localparam int unsigned PIN_D2  = 0;
    localparam int unsigned PIN_D3  = 1;
    localparam int unsigned PIN_D4  = 2;
    localparam int unsigned PIN_D5  = 3;
    localparam int unsigned PIN_CMP = 4;
    localparam int unsigned PIN_PF0 = 5;

    typedef enum logic [1:0] {
        SYNC_WARM_A,
        SYNC_WARM_B,
        SYNC_WARM_C,
        SYNC_ARMED
    } sync_state_e;

endpackage

// File: rtl/evirq_edge_sync.sv
module evirq_edge_sync
    import evirq_pkg::*;
#(
    parameter int unsigned W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o,
    output logic         armed_o
);

    sync_state_e state_q;
    sync_state_e state_d;

    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;
    logic [W-1:0] prev_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SYNC_WARM_A;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SYNC_WARM_A: state_d = SYNC_WARM_B;
            SYNC_WARM_B: state_d = SYNC_WARM_C;
            SYNC_WARM_C: state_d = SYNC_ARMED;
            SYNC_ARMED:  state_d = SYNC_ARMED;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        armed_o = 1'b0;
        unique case (state_q)
            SYNC_WARM_A,
            SYNC_WARM_B,
            SYNC_WARM_C: armed_o = 1'b0;
            SYNC_ARMED:  armed_o = 1'b1;
        endcase
    end

    // Per-pin synchronizer and edge detector
    for (genvar p = 0; p < W; p++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[p] <= 1'b0;
                stab_q[p] <= 1'b0;
                prev_q[p] <= 1'b0;
            end else begin
                meta_q[p] <= pin_i[p];
                stab_q[p] <= meta_q[p];
                prev_q[p] <= stab_q[p];
            end
        end

        assign rise_o[p] = armed_o &  stab_q[p] & ~prev_q[p];
        assign fall_o[p] = armed_o & ~stab_q[p] &  prev_q[p];
    end

endmodule

// File: rtl/evirq_flag_reg.sv
module evirq_flag_reg
    import evirq_pkg::*;
#(
    parameter int unsigned N  = NUM_LVL,
    parameter int unsigned IW = LVL_W
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [N-1:0]  wr_data,
    input  logic          clr_en,
    input  logic [IW-1:0] clr_idx,
    input  logic [N-1:0]  set_vec,
    output logic [N-1:0]  flag_o
);

    logic [N-1:0] flag_q;
    logic [N-1:0] flag_d;

    for (genvar b = 0; b < N; b++) begin : g_bit
        logic hit;
        assign hit       = clr_en && (clr_idx == IW'(b));
        assign flag_d[b] = set_vec[b] | (wr_en ? wr_data[b] : (flag_q[b] & ~hit));
    end

    // No reset: contents are kept across a controller reset
    always_ff @(posedge clk) begin
        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/evirq_prio_enc.sv
module evirq_prio_enc
    import evirq_pkg::*;
#(
    parameter int unsigned N  = NUM_LVL,
    parameter int unsigned IW = LVL_W
) (
    input  logic [N-1:0]  req_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);

    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IW'(i);
            end
        end
    end

endmodule

// File: rtl/evirq_ctrl.sv
module evirq_ctrl
    import evirq_pkg::*;
#(
    parameter int unsigned PF_W      = 8,
    parameter int unsigned ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(8'h38),
    parameter logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(8'h39)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              dac_uf,
    input  logic              t1_uf,
    input  logic              t2_uf,
    input  logic [3:0]        pd_pin,
    input  logic [PF_W-1:0]   pf_pin,
    input  logic              cmp_in,
    input  logic              cmp_en,
    input  logic              irq_ack,
    output logic              irq,
    output logic [LVL_W-1:0]  irq_level
);

    localparam int unsigned SYNC_W = PIN_PF0 + PF_W;

    logic [SYNC_W-1:0]  pin_vec;
    logic [SYNC_W-1:0]  rise_v;
    logic [SYNC_W-1:0]  fall_v;
    logic               armed;
    logic [NUM_LVL-1:0] event_v;
    logic [NUM_LVL-1:0] flag_q;
    logic [NUM_LVL-1:0] mask_q;
    logic [NUM_LVL-1:0] pend_v;
    logic               flag_wr;
    logic               mask_wr;

    assign pin_vec = {pf_pin, cmp_in, pd_pin};

    evirq_edge_sync #(.W(SYNC_W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_vec),
        .rise_o (rise_v),
        .fall_o (fall_v),
        .armed_o(armed)
    );

    // Source routing, one level per flag bit
    always_comb begin
        event_v          = '0;
        event_v[LVL_DAC] = dac_uf;
        event_v[LVL_T1]  = t1_uf;
        event_v[LVL_T2]  = t2_uf;
        event_v[LVL_D2R] = rise_v[PIN_D2];
        event_v[LVL_D3F] = fall_v[PIN_D3];
        event_v[LVL_PFF] = |fall_v[SYNC_W-1:PIN_PF0];
        event_v[LVL_D4R] = cmp_en ? rise_v[PIN_CMP] : rise_v[PIN_D4];
        event_v[LVL_D5F] = cmp_en ? fall_v[PIN_CMP] : fall_v[PIN_D5];
    end

    assign flag_wr = io_wr && (io_addr == FLAG_ADDR);
    assign mask_wr = io_wr && (io_addr == MASK_ADDR);

    evirq_flag_reg #(.N(NUM_LVL), .IW(LVL_W)) u_flags (
        .clk    (clk),
        .wr_en  (flag_wr),
        .wr_data(io_wdata),
        .clr_en (irq_ack && irq),
        .clr_idx(irq_level),
        .set_vec(event_v),
        .flag_o (flag_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_wr) begin
            mask_q <= io_wdata;
        end
    end

    assign pend_v = flag_q & mask_q;

    evirq_prio_enc #(.N(NUM_LVL), .IW(LVL_W)) u_prio (
        .req_i(pend_v),
        .any_o(irq),
        .idx_o(irq_level)
    );

    always_comb begin
        if (io_addr == MASK_ADDR) begin
            io_rdata = mask_q;
        end else if (io_addr == FLAG_ADDR) begin
            io_rdata = flag_q;
        end else begin
            io_rdata = '0;
        end
    end

endmodule

// File: rtl/evirq_ctrl_chk.sv
module evirq_ctrl_chk
    import evirq_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(8'h39)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               io_wr,
    input logic [ADDR_W-1:0]  io_addr,
    input logic [7:0]         io_wdata,
    input logic               irq_ack,
    input logic               irq,
    input logic [LVL_W-1:0]   irq_level,
    input logic [NUM_LVL-1:0] flag_q,
    input logic [NUM_LVL-1:0] mask_q,
    input logic [NUM_LVL-1:0] event_v
);

    logic [NUM_LVL-1:0] below;
    logic               fwr;

    assign below = (NUM_LVL'(1) << irq_level) - NUM_LVL'(1);
    assign fwr   = io_wr && (io_addr == FLAG_ADDR);

    // R6: the presented level is pending and enabled
    a_r6_level_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_q[irq_level] && mask_q[irq_level]));

    // R6: no higher-priority level is pending and enabled
    a_r6_level_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((flag_q & mask_q & below) == '0));

    // R6: request low means nothing enabled is pending
    a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> ((flag_q & mask_q) == '0));

    // R5: every event is latched on the next edge
    a_r5_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (event_v != '0) |=> ((flag_q & $past(event_v)) == $past(event_v)));

    // R7: write loads data, events still set their bits
    a_r7_write_load: assert property (@(posedge clk) disable iff (!rst_n)
        fwr |=> (flag_q == ($past(io_wdata) | $past(event_v))));

    // R8: acknowledge clears the presented level
    a_r8_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq && !fwr && !event_v[irq_level]) |=> !flag_q[$past(irq_level)]);

    // R3: mask is clear at the first edge after reset release
    a_r3_mask_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask_q == '0));

endmodule

bind evirq_ctrl evirq_ctrl_chk #(.ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_wr    (io_wr),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .irq_ack  (irq_ack),
    .irq      (irq),
    .irq_level(irq_level),
    .flag_q   (flag_q),
    .mask_q   (mask_q),
    .event_v  (event_v)
);

// File: tb/evirq_ctrl_test.sv
`timescale 1ns/1ps
module evirq_ctrl_test;

    localparam int PF_W = 8;
    localparam int PW   = 5 + PF_W;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] io_addr;
    logic       io_wr;
    logic [7:0] io_wdata;
    logic [7:0] io_rdata;
    logic       dac_uf, t1_uf, t2_uf;
    logic [3:0] pd_pin;
    logic [PF_W-1:0] pf_pin;
    logic       cmp_in, cmp_en, irq_ack;
    logic       irq;
    logic [2:0] irq_level;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    evirq_ctrl #(.PF_W(PF_W)) uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .dac_uf(dac_uf),
        .t1_uf(t1_uf), .t2_uf(t2_uf), .pd_pin(pd_pin), .pf_pin(pf_pin),
        .cmp_in(cmp_in), .cmp_en(cmp_en), .irq_ack(irq_ack),
        .irq(irq), .irq_level(irq_level)
    );

    // ---------------- reference model ----------------
    logic [7:0]    m_flags;
    logic [7:0]    m_mask = 8'h00;
    bit            known  = 0;
    logic [PW-1:0] hist[$];

    function automatic int lowest(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 0;
    endfunction

    always @(negedge rst_n) begin
        m_mask = 8'h00;
        hist.delete();
    end

    always @(posedge clk) begin
        logic [7:0]    ev;
        logic [7:0]    nf;
        logic [PW-1:0] a, b, r, f;
        ev = 8'h00;
        ev[0] = dac_uf; ev[1] = t1_uf; ev[2] = t2_uf;
        if (!rst_n) begin
            hist.delete();
        end else begin
            if (hist.size() >= 3) begin
                a = hist[hist.size()-2];
                b = hist[hist.size()-3];
                r = a & ~b;
                f = ~a & b;
                ev[3] = r[0];
                ev[4] = f[1];
                ev[5] = |f[PW-1:5];
                ev[6] = cmp_en ? r[4] : r[2];
                ev[7] = cmp_en ? f[4] : f[3];
            end
            hist.push_back({pf_pin, cmp_in, pd_pin});
            if (hist.size() > 4) void'(hist.pop_front());
        end
        nf = m_flags;
        if (io_wr && io_addr == 8'h39) begin
            nf = io_wdata;
            known = 1;
        end else if (irq_ack && known && ((m_flags & m_mask) != 0)) begin
            nf[lowest(m_flags & m_mask)] = 1'b0;
        end
        nf = nf | ev;
        if (!rst_n) m_mask = 8'h00;
        else if (io_wr && io_addr == 8'h38) m_mask = io_wdata;
        m_flags = nf;
    end

    // Per-cycle comparison
    always @(negedge clk) begin
        logic [7:0] er;
        logic       ei;
        if (known && !done) begin
            ei = (m_flags & m_mask) != 0;
            er = (io_addr == 8'h38) ? m_mask : (io_addr == 8'h39) ? m_flags : 8'h00;
            checks++;
            if (irq !== ei || irq_level !== 3'(ei ? lowest(m_flags & m_mask) : 0)) begin
                errors++;
                $display("FAIL R6 model irq/level: got %b/%0d expected %b/%0d",
                         irq, irq_level, ei, ei ? lowest(m_flags & m_mask) : 0);
            end
            checks++;
            if (io_rdata !== er) begin
                errors++;
                $display("FAIL R1 model rdata @%h: got %h expected %h", io_addr, io_rdata, er);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wcyc(input int n);
        repeat (n) step();
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        io_wr = 1; io_addr = a; io_wdata = d;
        step();
        io_wr = 0;
    endtask

    task automatic chk8(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
        io_addr = a;
        @(negedge clk);
        chk8(tag, io_rdata, exp);
        #1;
    endtask

    task automatic chk_irq(input string tag, input logic ei, input logic [2:0] el);
        @(negedge clk);
        chk8(tag, {4'h0, irq, irq_level}, {4'h0, ei, el});
        #1;
    endtask

    // ---------------- stimulus ----------------
    initial begin
        rst_n = 1; io_addr = 8'h38; io_wr = 0; io_wdata = 0;
        dac_uf = 0; t1_uf = 0; t2_uf = 0; pd_pin = 4'h0; pf_pin = '1;
        cmp_in = 0; cmp_en = 0; irq_ack = 0;
        #1 rst_n = 0;
        wcyc(4);
        rst_n = 1;
        rd("R3 mask after reset", 8'h38, 8'h00);
        chk_irq("R3 irq after reset", 1'b0, 3'd0);
        wcyc(6);
        wr(8'h39, 8'h00);

        // R5 / R4 timer sources with mask clear
        dac_uf = 1; step(); dac_uf = 0;
        rd("R5 masked dac latched", 8'h39, 8'h01);
        t1_uf = 1; step(); t1_uf = 0;
        rd("R4 t1 bit1", 8'h39, 8'h03);
        t2_uf = 1; step(); t2_uf = 0;
        rd("R4 t2 bit2", 8'h39, 8'h07);

        // R9 latency on pd_pin[0]
        pd_pin[0] = 1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); chk8("R9 not yet at n+1", io_rdata, 8'h07);
        @(posedge clk);
        @(negedge clk); chk8("R9 set at n+2", io_rdata, 8'h0F);
        #1;

        pd_pin[1] = 1; wcyc(4);
        rd("R4 d3 rise ignored", 8'h39, 8'h0F);
        pd_pin[1] = 0; wcyc(4);
        rd("R4 d3 fall bit4", 8'h39, 8'h1F);
        pf_pin[3] = 0; wcyc(4);
        rd("R12 pf fall bit5", 8'h39, 8'h3F);
        pf_pin[3] = 1; wcyc(4);
        rd("R12 pf rise ignored", 8'h39, 8'h3F);
        pd_pin[2] = 1; wcyc(4);
        rd("R4 d4 rise bit6", 8'h39, 8'h7F);
        pd_pin[3] = 1; wcyc(4);
        rd("R4 d5 rise ignored", 8'h39, 8'h7F);
        pd_pin[3] = 0; wcyc(4);
        rd("R4 d5 fall bit7", 8'h39, 8'hFF);

        // R1 address decode
        rd("R1 other address", 8'h3A, 8'h00);
        wr(8'h38, 8'hFF);
        rd("R1 mask readback", 8'h38, 8'hFF);

        // R6 / R8 acknowledge walks down the priorities
        io_addr = 8'h39;
        for (int i = 0; i < 8; i++) begin
            chk_irq("R6 priority walk", 1'b1, 3'(i));
            irq_ack = 1; step(); irq_ack = 0;
        end
        rd("R8 all acked", 8'h39, 8'h00);
        chk_irq("R6 none pending", 1'b0, 3'd0);

        // R6 mask gating
        wr(8'h39, 8'h0F); wr(8'h38, 8'hF0);
        chk_irq("R6 masked off", 1'b0, 3'd0);
        wr(8'h39, 8'h30);
        chk_irq("R6 lowest enabled", 1'b1, 3'd4);
        wr(8'h38, 8'h20);
        chk_irq("R6 single enabled", 1'b1, 3'd5);

        // R8 corner cases
        wr(8'h38, 8'h00); wr(8'h39, 8'h01);
        irq_ack = 1; step(); irq_ack = 0;
        rd("R8 ack ignored when idle", 8'h39, 8'h01);
        wr(8'h38, 8'h01);
        irq_ack = 1; dac_uf = 1; step(); irq_ack = 0; dac_uf = 0;
        rd("R8 event beats ack", 8'h39, 8'h01);
        irq_ack = 1; io_wr = 1; io_addr = 8'h39; io_wdata = 8'h03;
        step(); irq_ack = 0; io_wr = 0;
        rd("R8 write beats ack", 8'h39, 8'h03);

        // R7 write with same-cycle event
        t2_uf = 1; io_wr = 1; io_addr = 8'h39; io_wdata = 8'h00;
        step(); t2_uf = 0; io_wr = 0;
        rd("R7 event kept on write", 8'h39, 8'h04);

        // R11 comparator selection
        wr(8'h39, 8'h00); wr(8'h38, 8'h00);
        cmp_en = 1;
        pd_pin[2] = 0; wcyc(4);
        pd_pin[2] = 1; wcyc(4);
        pd_pin[3] = 1; wcyc(4);
        pd_pin[3] = 0; wcyc(4);
        rd("R11 port pins ignored", 8'h39, 8'h00);
        cmp_in = 1; wcyc(4);
        rd("R11 cmp rise bit6", 8'h39, 8'h40);
        cmp_in = 0; wcyc(4);
        rd("R11 cmp fall bit7", 8'h39, 8'hC0);
        cmp_en = 0;
        wr(8'h39, 8'h00);
        cmp_in = 1; wcyc(4);
        cmp_in = 0; wcyc(4);
        rd("R11 cmp ignored", 8'h39, 8'h00);
        pd_pin[2] = 0; wcyc(4);
        pd_pin[2] = 1; wcyc(4);
        rd("R11 port pin restored", 8'h39, 8'h40);

        // R2 / R10 retention across reset
        wr(8'h39, 8'h52); wr(8'h38, 8'hFF);
        pd_pin[0] = 0; wcyc(4);
        rd("R2 before reset", 8'h39, 8'h52);
        chk_irq("R6 before reset", 1'b1, 3'd1);
        rst_n = 0; pd_pin[0] = 1;
        wcyc(3);
        rd("R2 flags in reset", 8'h39, 8'h52);
        rd("R3 mask in reset", 8'h38, 8'h00);
        chk_irq("R3 irq in reset", 1'b0, 3'd0);
        rst_n = 1;
        wcyc(8);
        rd("R10 no edge from reset level", 8'h39, 8'h52);
        rd("R3 mask after release", 8'h38, 8'h00);

        finish_run();
    end

endmodule